// File: doc/BRIEF.md
# Handshaked Parallel I/O Port

This block is a byte-wide peripheral port placed between a processor register interface and an external parallel bus. Software picks one of four operating modes. Output mode passes bytes out under a ready/strobe handshake. Input mode takes bytes in under the same kind of handshake. Bidirectional mode carries both directions, gating its output drive with the strobe. Control mode sets the direction of each line separately and ignores the handshake completely.

The processor side has a one-bit register select: data or control. It has write and read enables and a combinational read-data bus. The peripheral side has separate in, out and output-enable vectors standing in for tri-state pads. It has two active-low strobe inputs with matching ready outputs: the primary pair for this port and a companion pair that only bidirectional mode uses. The strobes are asynchronous and each passes through a synchronizer. A completed handshake sets an interrupt request when interrupts are enabled. The request stays set until the processor acknowledges it.

Top module: `hs_pio_port`

## Requirements
- R1: After reset the mode is input (code 1), both ready outputs are low, the interrupt request is low, interrupts are disabled, and `pin_oe` is all zeros.
- R2: A control write (`cpu_sel`=1) sets the mode from bits [1:0] (0 output, 1 input, 2 bidirectional, 3 control) and the interrupt enable from bit 2. Both ready outputs go low. A data access uses `cpu_sel`=0.
- R3: In output mode, a data write loads the output register, which drives `pin_out`. `pin_oe` is all ones, `a_rdy` rises and stays high until the peripheral strobes.
- R4: A strobe completes at the low-to-high transition of `a_stb_n` (or `b_stb_n`). After a two-flop synchronizer and an edge detector, the matching ready output falls on the third rising clock edge after the transition.
- R5: In input mode, `pin_oe` is all zeros. A data read raises `a_rdy`. A completed `a_stb_n` strobe latches `pin_in` into the input register, and data reads return that register.
- R6: In input mode, a strobe latches new data even while `a_rdy` is low, overwriting the earlier byte.
- R7: In bidirectional mode, a data write raises `a_rdy` and a data read raises `b_rdy`. Both can be high together. The `b_stb_n` strobe latches input data and clears `b_rdy`.
- R8: In bidirectional mode, `pin_oe` is all ones only while the synchronized `a_stb_n` is low, and all zeros otherwise.
- R9: The control write that follows a selection of control mode is taken as a direction mask, not as a mode word. A mask bit of 1 makes the line an input and 0 makes it an output, so `pin_oe` equals the inverted mask.
- R10: In control mode both ready outputs stay low and strobes raise neither ready nor interrupt. A data read returns `pin_in` on input bits and the output register on output bits.
- R11: A completed handshake strobe with interrupts enabled sets `irq`, which holds until `irq_ack`. With interrupts disabled, `irq` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register select: 0 data, 1 control |
| cpu_we | input | 1 | Register write enable |
| cpu_re | input | 1 | Register read enable |
| cpu_wdata | input | W | Write data |
| cpu_rdata | output | W | Read data (combinational) |
| pin_in | input | W | Peripheral bus input value |
| pin_out | output | W | Peripheral bus output value |
| pin_oe | output | W | Per-line output enable |
| a_stb_n | input | 1 | Primary strobe, active low, asynchronous |
| a_rdy | output | 1 | Primary ready |
| b_stb_n | input | 1 | Companion strobe, active low, asynchronous |
| b_rdy | output | 1 | Companion ready |
| irq | output | 1 | Interrupt request level |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
The bench uses the default width of eight lines and the two-stage strobe synchronizer. With these values every mask pattern in the control-mode vector table maps to one byte that is easy to read. The three-edge latency from strobe release to ready falling becomes a fixed count the bench can sample around. With eight lines, mixed masks such as alternating bits and split nibbles show that the read path and drive path select per line rather than per byte.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        MODE_OUT   = 2'd0,
        MODE_IN    = 2'd1,
        MODE_BIDIR = 2'd2,
        MODE_CTRL  = 2'd3
    } pio_mode_e;

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    typedef struct packed {
        logic      irq_en;
        pio_mode_e mode;
    } pio_ctrl_t;

    function automatic pio_ctrl_t decode_ctrl(input logic [2:0] word);
        pio_ctrl_t c;
        c.irq_en = word[2];
        c.mode   = pio_mode_e'(word[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/pio_sync_edge.sv
module pio_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_n,
    output logic active,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-1:0], stb_n};
    end

    assign active = ~chain_q[LAST];
    assign rise   = chain_q[LAST] & ~chain_q[STAGES];
endmodule

// File: rtl/pio_bus_mux.sv
module pio_bus_mux
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  pio_mode_e      mode,
    input  logic [W-1:0]   mask,
    input  logic [W-1:0]   out_reg,
    input  logic [W-1:0]   in_reg,
    input  logic [W-1:0]   pin_in,
    input  logic           a_active,
    output logic [W-1:0]   pin_oe,
    output logic [W-1:0]   rdata
);
    always_comb begin
        unique case (mode)
            MODE_OUT: begin
                pin_oe = '1;
                rdata  = out_reg;
            end
            MODE_IN: begin
                pin_oe = '0;
                rdata  = in_reg;
            end
            MODE_BIDIR: begin
                pin_oe = {W{a_active}};
                rdata  = in_reg;
            end
            default: begin
                pin_oe = ~mask;
                rdata  = (pin_in & mask) | (out_reg & ~mask);
            end
        endcase
    end
endmodule

// File: rtl/hs_pio_port.sv
module hs_pio_port
    import pio_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cpu_sel,
    input  logic         cpu_we,
    input  logic         cpu_re,
    input  logic [W-1:0] cpu_wdata,
    output logic [W-1:0] cpu_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    input  logic         a_stb_n,
    output logic         a_rdy,
    input  logic         b_stb_n,
    output logic         b_rdy,
    output logic         irq,
    input  logic         irq_ack
);
    localparam int NSTB = 2;

    pio_mode_e   mode_q;
    logic        ie_q, mask_pend_q;
    logic [W-1:0] out_q, in_q, mask_q;
    logic        a_rdy_q, b_rdy_q, irq_q;

    logic [NSTB-1:0] stb_n_v, stb_act, stb_rise;
    assign stb_n_v = {b_stb_n, a_stb_n};

    for (genvar i = 0; i < NSTB; i++) begin : g_sync
        pio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .stb_n  (stb_n_v[i]),
            .active (stb_act[i]),
            .rise   (stb_rise[i])
        );
    end

    logic      ctrl_wr, data_wr, data_rd, hs_event;
    pio_ctrl_t ctrl_word;

    assign ctrl_wr   = cpu_we && (cpu_sel == SEL_CTRL);
    assign data_wr   = cpu_we && (cpu_sel == SEL_DATA);
    assign data_rd   = cpu_re && (cpu_sel == SEL_DATA);
    assign ctrl_word = decode_ctrl(cpu_wdata[2:0]);
    assign hs_event  = !ctrl_wr && (mode_q != MODE_CTRL) &&
                       (stb_rise[0] || (mode_q == MODE_BIDIR && stb_rise[1]));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_IN;
            ie_q        <= 1'b0;
            mask_pend_q <= 1'b0;
            mask_q      <= '1;
            out_q       <= '0;
            in_q        <= '0;
            a_rdy_q     <= 1'b0;
            b_rdy_q     <= 1'b0;
        end else if (ctrl_wr) begin
            if (mask_pend_q) begin
                mask_q      <= cpu_wdata;
                mask_pend_q <= 1'b0;
            end else begin
                mode_q      <= ctrl_word.mode;
                ie_q        <= ctrl_word.irq_en;
                mask_pend_q <= (ctrl_word.mode == MODE_CTRL);
                a_rdy_q     <= 1'b0;
                b_rdy_q     <= 1'b0;
            end
        end else begin
            if (data_wr) out_q <= cpu_wdata;
            unique case (mode_q)
                MODE_OUT: begin
                    if (stb_rise[0]) a_rdy_q <= 1'b0;
                    if (data_wr)     a_rdy_q <= 1'b1;
                end
                MODE_IN: begin
                    if (stb_rise[0]) begin
                        in_q    <= pin_in;
                        a_rdy_q <= 1'b0;
                    end
                    if (data_rd) a_rdy_q <= 1'b1;
                end
                MODE_BIDIR: begin
                    if (stb_rise[0]) a_rdy_q <= 1'b0;
                    if (data_wr)     a_rdy_q <= 1'b1;
                    if (stb_rise[1]) begin
                        in_q    <= pin_in;
                        b_rdy_q <= 1'b0;
                    end
                    if (data_rd) b_rdy_q <= 1'b1;
                end
                default: begin
                    a_rdy_q <= 1'b0;
                    b_rdy_q <= 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  irq_q <= 1'b0;
        else if (hs_event && ie_q) irq_q <= 1'b1;
        else if (irq_ack)         irq_q <= 1'b0;
    end

    pio_bus_mux #(.W(W)) u_mux (
        .mode     (mode_q),
        .mask     (mask_q),
        .out_reg  (out_q),
        .in_reg   (in_q),
        .pin_in   (pin_in),
        .a_active (stb_act[0]),
        .pin_oe   (pin_oe),
        .rdata    (cpu_rdata)
    );

    assign pin_out = out_q;
    assign a_rdy   = a_rdy_q;
    assign b_rdy   = b_rdy_q;
    assign irq     = irq_q;
endmodule

// File: rtl/pio_port_checker.sv
module pio_port_checker
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input pio_mode_e    mode,
    input logic         ie,
    input logic         cpu_sel,
    input logic         cpu_we,
    input logic         a_rdy,
    input logic         b_rdy,
    input logic         irq,
    input logic         irq_ack,
    input logic [W-1:0] pin_oe
);
    // R10: control mode keeps both ready lines low
    p_ctrl_rdy_low_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CTRL) |-> (!a_rdy && !b_rdy));

    // R7: companion ready is used only by bidirectional mode
    p_b_rdy_bidir_r7: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_BIDIR) |-> !b_rdy);

    // R3: output mode drives every line
    p_out_oe_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OUT) |-> (pin_oe == '1));

    // R5: input mode drives no line
    p_in_oe_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IN) |-> (pin_oe == '0));

    // R3: data write in output mode raises ready next cycle
    p_wr_rdy_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OUT && cpu_we && cpu_sel == SEL_DATA) |=> a_rdy);

    // R11: request holds until acknowledged
    p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq);

    // R11: no request with interrupts disabled
    p_irq_off_r11: assert property (@(posedge clk) disable iff (rst)
        (!ie && !irq) |=> !irq);

    // R8: bidirectional drive is all or nothing
    p_bidir_oe_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BIDIR) |-> (pin_oe == '0 || pin_oe == '1));
endmodule

bind hs_pio_port pio_port_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .ie      (ie_q),
    .cpu_sel (cpu_sel),
    .cpu_we  (cpu_we),
    .a_rdy   (a_rdy),
    .b_rdy   (b_rdy),
    .irq     (irq),
    .irq_ack (irq_ack),
    .pin_oe  (pin_oe)
);

// File: tb/sim_hs_pio_port.sv
`timescale 1ns/1ps
module sim_hs_pio_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_sel = 1'b0, cpu_we = 1'b0, cpu_re = 1'b0, irq_ack = 1'b0;
    logic [W-1:0] cpu_wdata = '0, pin_in = '0;
    logic         a_stb_n = 1'b1, b_stb_n = 1'b1;
    logic [W-1:0] cpu_rdata, pin_out, pin_oe;
    logic         a_rdy, b_rdy, irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hs_pio_port #(.W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .a_stb_n(a_stb_n), .a_rdy(a_rdy),
        .b_stb_n(b_stb_n), .b_rdy(b_rdy), .irq(irq), .irq_ack(irq_ack)
    );

    // control-mode vectors: {mask, out value, pin value, expected read}
    localparam logic [31:0] VEC [5] = '{
        32'hF0_5A_3C_3A,
        32'h0F_A5_C3_A3,
        32'hFF_00_96_96,
        32'h00_7E_FF_7E,
        32'hAA_55_FF_FF
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [W-1:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(output logic [W-1:0] d);
        @(negedge clk);
        cpu_sel = 1'b0; cpu_re = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_re = 1'b0;
    endtask

    task automatic strobe(input bit use_b);
        @(negedge clk);
        if (use_b) b_stb_n = 1'b0; else a_stb_n = 1'b0;
        repeat (4) @(negedge clk);
        if (use_b) b_stb_n = 1'b1; else a_stb_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk("R1 a_rdy", a_rdy, 0);
        chk("R1 b_rdy", b_rdy, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pin_oe", pin_oe, 0);

        // R9 R10 vector table
        foreach (VEC[i]) begin
            wr(1'b1, 8'h03);
            wr(1'b1, VEC[i][31:24]);
            wr(1'b0, VEC[i][23:16]);
            pin_in = VEC[i][15:8];
            #1;
            chk("R9 pin_oe", pin_oe, {24'h0, ~VEC[i][31:24]});
            rd(d);
            chk("R10 read mix", d, VEC[i][7:0]);
        end

        // R10 strobes ignored in control mode, even with interrupts on (R2 bit2)
        wr(1'b1, 8'h07);
        wr(1'b1, 8'h0F);
        strobe(1'b0);
        strobe(1'b1);
        chk("R10 a_rdy", a_rdy, 0);
        chk("R10 b_rdy", b_rdy, 0);
        chk("R10 irq", irq, 0);

        // R2 R3 output mode, interrupts enabled
        wr(1'b1, 8'h04);
        chk("R3 oe", pin_oe, 8'hFF);
        wr(1'b0, 8'hC5);
        chk("R3 pin_out", pin_out, 8'hC5);
        chk("R3 a_rdy", a_rdy, 1);
        // R4 latency: ready falls at the third edge after release
        @(negedge clk); a_stb_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 rdy held", a_rdy, 1);
        a_stb_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R4 rdy before 3rd edge", a_rdy, 1);
        @(negedge clk);
        chk("R4 rdy after 3rd edge", a_rdy, 0);
        chk("R11 irq set", irq, 1);
        repeat (3) @(negedge clk);
        chk("R11 irq held", irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R11 irq acked", irq, 0);

        // R11 disabled interrupts
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h11);
        strobe(1'b0);
        chk("R11 no irq", irq, 0);
        chk("R4 rdy cleared", a_rdy, 0);

        // R5 input mode
        wr(1'b1, 8'h01);
        chk("R5 oe", pin_oe, 0);
        rd(d);
        chk("R5 rdy after read", a_rdy, 1);
        pin_in = 8'h6B;
        strobe(1'b0);
        chk("R5 rdy after strobe", a_rdy, 0);
        rd(d);
        chk("R5 latched", d, 8'h6B);
        // R6 overrun: strobe while ready low (read just re-raised it, clear it first)
        strobe(1'b0);
        chk("R6 rdy low", a_rdy, 0);
        pin_in = 8'h94;
        strobe(1'b0);
        rd(d);
        chk("R6 overwrite", d, 8'h94);

        // R7 R8 bidirectional
        wr(1'b1, 8'h06);
        chk("R8 oe idle", pin_oe, 0);
        wr(1'b0, 8'h3E);
        rd(d);
        chk("R7 a_rdy", a_rdy, 1);
        chk("R7 b_rdy", b_rdy, 1);
        @(negedge clk); a_stb_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 oe during strobe", pin_oe, 8'hFF);
        chk("R8 pin_out", pin_out, 8'h3E);
        a_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 oe after strobe", pin_oe, 0);
        chk("R7 a_rdy cleared", a_rdy, 0);
        chk("R7 b_rdy kept", b_rdy, 1);
        chk("R11 irq bidir", irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        pin_in = 8'hD2;
        strobe(1'b1);
        chk("R7 b_rdy cleared", b_rdy, 0);
        chk("R11 irq companion", irq, 1);
        rd(d);
        chk("R7 input latched", d, 8'hD2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule